// File: doc/BRIEF.md
# Multi-Mode Display Host Interface

This block is the host-facing front end of a character display controller. A microcontroller talks to it over one of three bus styles picked by two static pins: a Motorola-style parallel bus (enable plus read/write level), an Intel-style parallel bus (separate read and write strobes) or a strobe-framed serial port. Each transfer is steered to the instruction register or the data register. Every completed write comes out as a one-cycle pulse in the system clock domain, carrying the register flag and the byte.

On the parallel buses the word length is eight or four bits. It is chosen by a function-set instruction, not by a pin. In four-bit mode only the upper half of the data lines carries data, and each byte moves as two nibbles, high nibble first. On the serial port a start byte carries the register flag and the read/write choice, and a data byte follows it, MSB first. For reads, a byte from an internal source is driven onto the parallel lines or shifted out on the serial output. A completion pulse lets that source advance.

All external strobes pass through synchronizers before their edges are detected. Data and register-select pins are sampled when a detected edge acts on them, so the host holds them for a few system clocks after the strobe edge.

Top module: `dhi_host_if`

## Requirements
- R1: `mode_par`=0 selects the serial port and `mode_par`=1 the parallel port. With `mode_par`=1, `bus_m68`=1 selects Motorola timing and 0 selects Intel timing. Strobes of the unselected port have no effect.
- R2: On a parallel transfer, `reg_sel`=0 addresses the instruction register and 1 the data register. The value is reported on `wr_rs` with the write, and on `rd_rs` during a read.
- R3: In Motorola mode, a falling edge of `en_rdn` with `rw_wrn`=0 writes `db_in`. While `en_rdn`=1 and `rw_wrn`=1, `db_oe`=1 and `db_out` carries the source byte. The falling edge of `en_rdn` ends the read.
- R4: In Intel mode, a rising edge of `rw_wrn` writes `db_in`. While `en_rdn`=0, `db_oe`=1 and `db_out` carries the source byte. The rising edge of `en_rdn` ends the read.
- R5: While `cs_n`=1, no write, read completion or output enable is produced by either port.
- R6: An instruction-register write whose byte has bits 7:5 = 001 is a function set. Its bit 4 selects the word length: 1 for eight bits, 0 for four bits. The write also returns the nibble phase to high. After reset the width is eight bits.
- R7: In four-bit mode only `db_in[7:4]` is used, and the high nibble comes first. One write pulse follows the second nibble. Reads return the high nibble on `db_out[7:4]`, then the low nibble, and `rd_done` follows the second nibble.
- R8: A serial frame opens when `stb_n` falls. Bits are taken from `sdi` on rising `sck` edges, MSB first. The first byte is the start byte: bit 6 is the register flag and bit 5 selects read (1) or write (0). A write frame of exactly 16 bits issues its write when `stb_n` rises.
- R9: In a serial read frame, after the eighth bit `sdo_en`=1 and `sdo` presents the source byte MSB first. The output advances after each further rising `sck`. `rd_done` pulses when `stb_n` rises after 16 bits.
- R10: A serial frame closed with any bit count other than 16 is discarded, and the next frame works normally.
- R11: `wr_valid` and `rd_done` are single-cycle pulses, and each transfer produces exactly one.
- R12: During and right after reset, `wr_valid`, `rd_done`, `db_oe` and `sdo_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_par | input | 1 | 1 parallel port, 0 serial port |
| bus_m68 | input | 1 | 1 Motorola timing, 0 Intel timing |
| cs_n | input | 1 | Active-low chip select |
| reg_sel | input | 1 | Parallel register select: 0 instruction, 1 data |
| rw_wrn | input | 1 | Motorola read/write level, or Intel write strobe (active low) |
| en_rdn | input | 1 | Motorola enable, or Intel read strobe (active low) |
| stb_n | input | 1 | Serial frame strobe, active low |
| sck | input | 1 | Serial shift clock |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sdo_en | output | 1 | Serial output enable |
| db_in | input | DW | Parallel data lines, inbound |
| db_out | output | DW | Parallel data lines, outbound |
| db_oe | output | 1 | Parallel output enable |
| src_byte | input | DW | Byte from the internal read source |
| rd_rs | output | 1 | Register addressed by the current read |
| rd_done | output | 1 | Pulse at the end of a read |
| wr_valid | output | 1 | Pulse for a completed write |
| wr_rs | output | 1 | Register flag of the write |
| wr_data | output | DW | Byte of the write |

## Verification
On every cycle, the assertions check that the write and read-completion pulses last one cycle and that the two output enables are never high together. They also check that a chip select held high longer than the synchronizer delay silences every pulse and enable. Whether the right byte reaches the right register can only be shown by the bench scenarios. The same holds for nibble order and phase, function-set switching of the word length, serial bit order in both directions, and the discarding of short frames. The bench compares those against its own model of the width and the framing.

// File: rtl/dhi_pkg.sv
package dhi_pkg;
   // function-set recognition (top three bits of the byte, width flag below)
   localparam logic [2:0] FSET_TAG = 3'b001;
   // serial start byte: bit positions of register flag and read flag
   localparam int SER_RS_BIT = 6;
   localparam int SER_RW_BIT = 5;
endpackage

// File: rtl/dhi_sync.sv
module dhi_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 1) begin : g_bad_stages
      $error("dhi_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= '1;
         else        q <= d;
      end
   end else begin : g_chain
      logic [STAGES*W-1:0] sh;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sh <= '1;
         else        sh <= {sh[(STAGES-1)*W-1:0], d};
      end
      assign q = sh[STAGES*W-1 -: W];
   end
endmodule

// File: rtl/dhi_par_port.sv
module dhi_par_port (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   input  logic m68,
   input  logic cs_s,
   input  logic rw_s,
   input  logic en_s,
   output logic ev_wr,
   output logic ev_rd_end,
   output logic rd_act
);
   logic rw_d, en_d;
   logic sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rw_d <= 1'b1;
         en_d <= 1'b1;
      end else begin
         rw_d <= rw_s;
         en_d <= en_s;
      end
   end

   assign sel = go & ~cs_s;

   always_comb begin
      if (m68) begin
         ev_wr     = sel & en_d & ~en_s & ~rw_s;
         ev_rd_end = sel & en_d & ~en_s &  rw_s;
         rd_act    = sel & en_s & rw_s;
      end else begin
         ev_wr     = sel & ~rw_d & rw_s;
         ev_rd_end = sel & ~en_d & en_s;
         rd_act    = sel & ~en_s;
      end
   end
endmodule

// File: rtl/dhi_ser_port.sv
module dhi_ser_port
   import dhi_pkg::*;
#(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          cs_s,
   input  logic          stb_s,
   input  logic          sck_s,
   input  logic          sdi,
   input  logic [DW-1:0] src_byte,
   output logic          ev_wr,
   output logic          ev_rd_end,
   output logic          rs_o,
   output logic [DW-1:0] data_o,
   output logic          sdo,
   output logic          sdo_en
);
   localparam int FRAME = 2 * DW;
   localparam int CMAX  = FRAME + 1;
   localparam int CW    = $clog2(CMAX + 1);

   logic          stb_d, sck_d;
   logic [CW-1:0] cnt;
   logic [DW-1:0] shreg, tx, nb;
   logic          rw_lat, pend, tx_en;
   logic          stb_fall, stb_rise, sck_rise, open_f, full;

   assign stb_fall = stb_d & ~stb_s;
   assign stb_rise = ~stb_d & stb_s;
   assign sck_rise = ~sck_d & sck_s;
   assign open_f   = go & ~cs_s & ~stb_s;
   assign nb       = {shreg[DW-2:0], sdi};
   assign full     = (cnt == CW'(FRAME));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_d  <= 1'b1;
         sck_d  <= 1'b1;
         cnt    <= '0;
         shreg  <= '0;
         tx     <= '0;
         rs_o   <= 1'b0;
         rw_lat <= 1'b0;
         pend   <= 1'b0;
         tx_en  <= 1'b0;
      end else begin
         stb_d <= stb_s;
         sck_d <= sck_s;
         if (pend) begin
            tx    <= src_byte;
            tx_en <= 1'b1;
            pend  <= 1'b0;
         end
         if (stb_fall) begin
            cnt   <= '0;
            tx_en <= 1'b0;
            pend  <= 1'b0;
         end else if (open_f && sck_rise) begin
            shreg <= nb;
            if (cnt != CW'(CMAX)) cnt <= cnt + 1'b1;
            if (cnt == CW'(DW - 1)) begin
               rs_o   <= nb[SER_RS_BIT];
               rw_lat <= nb[SER_RW_BIT];
               pend   <= nb[SER_RW_BIT];
            end
            if (tx_en) tx <= {tx[DW-2:0], 1'b0};
         end
         if (!open_f) begin
            tx_en <= 1'b0;
            pend  <= 1'b0;
         end
      end
   end

   assign ev_wr     = go & ~cs_s & stb_rise & full & ~rw_lat;
   assign ev_rd_end = go & ~cs_s & stb_rise & full &  rw_lat;
   assign data_o    = shreg;
   assign sdo       = tx[DW-1];
   assign sdo_en    = tx_en & open_f;
endmodule

// File: rtl/dhi_host_if.sv
module dhi_host_if
   import dhi_pkg::*;
#(
   parameter int   DW          = 8,
   parameter int   SYNC_STAGES = 2,
   parameter logic RESET_WIDE  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_par,
   input  logic          bus_m68,
   input  logic          cs_n,
   input  logic          reg_sel,
   input  logic          rw_wrn,
   input  logic          en_rdn,
   input  logic          stb_n,
   input  logic          sck,
   input  logic          sdi,
   output logic          sdo,
   output logic          sdo_en,
   input  logic [DW-1:0] db_in,
   output logic [DW-1:0] db_out,
   output logic          db_oe,
   input  logic [DW-1:0] src_byte,
   output logic          rd_rs,
   output logic          rd_done,
   output logic          wr_valid,
   output logic          wr_rs,
   output logic [DW-1:0] wr_data
);
   localparam int HW     = DW / 2;
   localparam int ARM_N  = SYNC_STAGES + 1;
   localparam int ARM_W  = $clog2(ARM_N + 1);
   localparam int DL_POS = DW - 4;

   if (DW < 8 || (DW % 2) != 0) begin : g_bad_dw
      $error("dhi_host_if: DW must be even and at least 8");
   end
   if (SYNC_STAGES < 1) begin : g_bad_sync
      $error("dhi_host_if: SYNC_STAGES must be at least 1");
   end

   logic [4:0] raw_v, syn_v;
   logic       cs_s, rw_s, en_s, stb_s, sck_s;
   logic [ARM_W-1:0] arm_cnt;
   logic       armed;

   assign raw_v = {cs_n, rw_wrn, en_rdn, stb_n, sck};
   dhi_sync #(.W(5), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_v), .q(syn_v)
   );
   assign {cs_s, rw_s, en_s, stb_s, sck_s} = syn_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      arm_cnt <= '0;
      else if (arm_cnt != ARM_W'(ARM_N)) arm_cnt <= arm_cnt + 1'b1;
   end
   assign armed = (arm_cnt == ARM_W'(ARM_N));

   logic p_wr, p_rd_end, p_rd_act;
   dhi_par_port u_par (
      .clk(clk), .rst_n(rst_n), .go(armed & mode_par), .m68(bus_m68),
      .cs_s(cs_s), .rw_s(rw_s), .en_s(en_s),
      .ev_wr(p_wr), .ev_rd_end(p_rd_end), .rd_act(p_rd_act)
   );

   logic          s_wr, s_rd_end, s_rs;
   logic [DW-1:0] s_data;
   dhi_ser_port #(.DW(DW)) u_ser (
      .clk(clk), .rst_n(rst_n), .go(armed & ~mode_par), .cs_s(cs_s),
      .stb_s(stb_s), .sck_s(sck_s), .sdi(sdi), .src_byte(src_byte),
      .ev_wr(s_wr), .ev_rd_end(s_rd_end), .rs_o(s_rs), .data_o(s_data),
      .sdo(sdo), .sdo_en(sdo_en)
   );

   // word length and nibble assembly
   logic          wide, phase_lo;
   logic [HW-1:0] hi_hold;
   logic          em_v, em_rs;
   logic [DW-1:0] em_d;

   always_comb begin
      em_v  = 1'b0;
      em_rs = reg_sel;
      em_d  = db_in;
      if (p_wr) begin
         if (wide) begin
            em_v = 1'b1;
         end else if (phase_lo) begin
            em_v = 1'b1;
            em_d = {hi_hold, db_in[DW-1:HW]};
         end
      end
      if (s_wr) begin
         em_v  = 1'b1;
         em_rs = s_rs;
         em_d  = s_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wide     <= RESET_WIDE;
         phase_lo <= 1'b0;
         hi_hold  <= '0;
         wr_valid <= 1'b0;
         wr_rs    <= 1'b0;
         wr_data  <= '0;
         rd_done  <= 1'b0;
      end else begin
         wr_valid <= em_v;
         rd_done  <= 1'b0;
         if (em_v) begin
            wr_rs   <= em_rs;
            wr_data <= em_d;
         end
         if (p_wr && !wide) begin
            phase_lo <= ~phase_lo;
            if (!phase_lo) hi_hold <= db_in[DW-1:HW];
         end
         if (p_rd_end) begin
            if (wide) begin
               rd_done <= 1'b1;
            end else begin
               phase_lo <= ~phase_lo;
               rd_done  <= phase_lo;
            end
         end
         if (s_rd_end) rd_done <= 1'b1;
         if (em_v && !em_rs && em_d[DW-1 -: 3] == FSET_TAG) begin
            wide     <= em_d[DL_POS];
            phase_lo <= 1'b0;
         end
      end
   end

   // read data path
   always_comb begin
      db_out = '0;
      if (p_rd_act) begin
         if (wide)          db_out = src_byte;
         else if (phase_lo) db_out = {src_byte[HW-1:0], {HW{1'b0}}};
         else               db_out = {src_byte[DW-1:HW], {HW{1'b0}}};
      end
   end
   assign db_oe = p_rd_act;
   assign rd_rs = mode_par ? reg_sel : s_rs;
endmodule

// File: rtl/dhi_host_if_chk.sv
module dhi_host_if_chk #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic wr_valid,
   input logic rd_done,
   input logic db_oe,
   input logic sdo_en
);
   localparam int QUIET = SYNC_STAGES + 1;
   localparam int QW    = $clog2(QUIET + 2);

   logic [QW-1:0] cs_hi_cnt;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            cs_hi_cnt <= '0;
      else if (!cs_n)                        cs_hi_cnt <= '0;
      else if (cs_hi_cnt != QW'(QUIET + 1))  cs_hi_cnt <= cs_hi_cnt + 1'b1;
   end

   AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !wr_valid); // R11
   AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_done |=> !rd_done); // R11
   AST_CS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_hi_cnt == QW'(QUIET + 1)) |-> !(wr_valid || rd_done || db_oe || sdo_en)); // R5
   AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
      !(db_oe && sdo_en)); // R1
endmodule

bind dhi_host_if dhi_host_if_chk #(.SYNC_STAGES(SYNC_STAGES)) u_chk (
   .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_valid(wr_valid),
   .rd_done(rd_done), .db_oe(db_oe), .sdo_en(sdo_en)
);

// File: tb/tb_dhi_host_if.sv
`timescale 1ns/1ps
module tb_dhi_host_if;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_par = 1'b1, bus_m68 = 1'b1, cs_n = 1'b1, reg_sel = 1'b0;
   logic rw_wrn = 1'b1, en_rdn = 1'b0, stb_n = 1'b1, sck = 1'b0, sdi = 1'b0;
   logic sdo, sdo_en, db_oe, rd_rs, rd_done, wr_valid, wr_rs;
   logic [7:0] db_in = '0, db_out, src_byte = '0, wr_data;

   always #5 clk = ~clk;

   dhi_host_if dut (
      .clk(clk), .rst_n(rst_n), .mode_par(mode_par), .bus_m68(bus_m68),
      .cs_n(cs_n), .reg_sel(reg_sel), .rw_wrn(rw_wrn), .en_rdn(en_rdn),
      .stb_n(stb_n), .sck(sck), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en),
      .db_in(db_in), .db_out(db_out), .db_oe(db_oe), .src_byte(src_byte),
      .rd_rs(rd_rs), .rd_done(rd_done), .wr_valid(wr_valid), .wr_rs(wr_rs),
      .wr_data(wr_data)
   );

   int checks = 0, fails = 0, rd_cnt = 0;
   bit finished = 0;
   logic [8:0] wq[$];
   bit wide_m = 1;

   always @(negedge clk) begin
      if (wr_valid) wq.push_back({wr_rs, wr_data});
      if (rd_done) rd_cnt++;
   end

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic void model_wr(input bit rs, input logic [7:0] d);
      if (!rs && d[7:5] == 3'b001) wide_m = d[4];
   endfunction

   task automatic expect_wr(input bit rs, input logic [7:0] d, input string tag);
      logic [8:0] got;
      wait_n(4);
      if (wq.size() != 1) begin
         chk(0, {tag, " pulse count"}, wq.size(), 1);
         wq.delete();
      end else begin
         got = wq.pop_front();
         chk(got == {rs, d}, tag, got, {rs, d});
      end
      model_wr(rs, d);
   endtask

   task automatic expect_none(input string tag);
      wait_n(4);
      chk(wq.size() == 0, tag, wq.size(), 0);
      wq.delete();
   endtask

   // style: 0 serial, 1 Intel, 2 Motorola
   task automatic select(input int style);
      cs_n = 1'b1;
      wait_n(2);
      mode_par = (style != 0);
      bus_m68  = (style == 2);
      rw_wrn   = (style == 2) ? 1'b0 : 1'b1;
      en_rdn   = (style == 2) ? 1'b0 : 1'b1;
      stb_n = 1'b1; sck = 1'b0;
      wait_n(6);
      cs_n = 1'b0;
      wait_n(6);
   endtask

   task automatic par_pulse(input bit rs, input logic [7:0] d);
      reg_sel = rs; db_in = d;
      if (bus_m68) begin
         rw_wrn = 1'b0; en_rdn = 1'b1; wait_n(6); en_rdn = 1'b0; wait_n(6);
      end else begin
         rw_wrn = 1'b0; wait_n(6); rw_wrn = 1'b1; wait_n(6);
      end
   endtask

   task automatic par_read(input bit rs, input logic [7:0] src,
                           input logic [7:0] exp, input string tag);
      reg_sel = rs; src_byte = src;
      if (bus_m68) begin rw_wrn = 1'b1; en_rdn = 1'b1; end
      else en_rdn = 1'b0;
      wait_n(6);
      chk(db_oe == 1'b1, {tag, " oe"}, db_oe, 1);
      chk(db_out == exp, {tag, " data"}, db_out, exp);
      chk(rd_rs == rs, {tag, " rs"}, rd_rs, rs);
      if (bus_m68) begin en_rdn = 1'b0; wait_n(6); rw_wrn = 1'b0; end
      else begin en_rdn = 1'b1; wait_n(6); end
   endtask

   task automatic ser_xfer(input logic [15:0] frame, input int nbits,
                           output logic [7:0] got);
      got = '0;
      stb_n = 1'b0; wait_n(6);
      for (int i = 0; i < nbits; i++) begin
         sck = 1'b0; sdi = frame[15-i]; wait_n(6);
         if (i >= 8) got = {got[6:0], sdo};
         sck = 1'b1; wait_n(6);
      end
      sck = 1'b0; wait_n(6);
      stb_n = 1'b1; wait_n(8);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      finish_run();
   end

   initial begin
      logic [7:0] got, d;
      int r0;
      bit rs;
      void'($urandom(32'h5EED1));
      // R12 reset state
      wait_n(3);
      chk({wr_valid, rd_done, db_oe, sdo_en} == 4'b0, "R12 in reset", {wr_valid, rd_done, db_oe, sdo_en}, 0);
      rst_n = 1'b1;
      wait_n(10);
      chk({wr_valid, rd_done, db_oe, sdo_en} == 4'b0, "R12 after reset", {wr_valid, rd_done, db_oe, sdo_en}, 0);

      // R3 Motorola writes and read, R2 register select
      select(2);
      par_pulse(0, 8'h38); expect_wr(0, 8'h38, "R6 fset keeps wide");
      par_pulse(1, 8'hA5); expect_wr(1, 8'hA5, "R3 m68 write R2 DR");
      r0 = rd_cnt;
      par_read(1, 8'h5A, 8'h5A, "R3 m68 read");
      chk(rd_cnt == r0 + 1, "R3 rd_done", rd_cnt - r0, 1);

      // R5 chip select high ignores bus
      cs_n = 1'b1; wait_n(6);
      par_pulse(1, 8'h77); expect_none("R5 cs high write");
      rw_wrn = 1'b1; en_rdn = 1'b1; wait_n(6);
      chk(db_oe == 1'b0, "R5 cs high read oe", db_oe, 0);
      en_rdn = 1'b0; wait_n(6);

      // R4 Intel writes and read
      select(1);
      par_pulse(0, 8'h01); expect_wr(0, 8'h01, "R4 i80 write R2 IR");
      par_pulse(1, 8'hC3); expect_wr(1, 8'hC3, "R4 i80 write DR");
      r0 = rd_cnt;
      par_read(0, 8'h3C, 8'h3C, "R4 i80 read");
      chk(rd_cnt == r0 + 1, "R4 rd_done", rd_cnt - r0, 1);

      // R6 switch to four-bit, R7 nibble transfers
      par_pulse(0, 8'h28); expect_wr(0, 8'h28, "R6 fset to narrow");
      par_pulse(1, 8'hA6); expect_none("R7 no pulse after high nibble");
      par_pulse(1, 8'h79); expect_wr(1, 8'hA7, "R7 nibble assembly");
      r0 = rd_cnt;
      par_read(1, 8'h9E, 8'h90, "R7 read high nibble");
      chk(rd_cnt == r0, "R7 no rd_done after high", rd_cnt - r0, 0);
      par_read(1, 8'h9E, 8'hE0, "R7 read low nibble");
      chk(rd_cnt == r0 + 1, "R7 rd_done after low", rd_cnt - r0, 1);
      select(2);
      par_pulse(0, 8'h3F); par_pulse(0, 8'h0C); expect_wr(0, 8'h30, "R6 fset back to wide");
      par_pulse(1, 8'h66); expect_wr(1, 8'h66, "R6 eight-bit again");

      // R8 serial writes, R9 read, R10 partial frame
      select(0);
      ser_xfer({8'h40, 8'hB2}, 16, got); expect_wr(1, 8'hB2, "R8 serial DR write");
      ser_xfer({8'h00, 8'h11}, 16, got); expect_wr(0, 8'h11, "R8 serial IR write");
      src_byte = 8'hD4; r0 = rd_cnt;
      ser_xfer({8'h60, 8'h00}, 16, got);
      chk(got == 8'hD4, "R9 serial read byte", got, 8'hD4);
      chk(rd_cnt == r0 + 1, "R9 serial rd_done", rd_cnt - r0, 1);
      chk(wq.size() == 0, "R9 no write on read", wq.size(), 0);
      ser_xfer({8'h40, 8'hEE}, 12, got); expect_none("R10 short frame dropped");
      ser_xfer({8'h40, 8'h5C}, 16, got); expect_wr(1, 8'h5C, "R10 frame after drop");

      // R1 parallel strobes ignored in serial mode
      reg_sel = 1'b1; db_in = 8'h99; rw_wrn = 1'b0; wait_n(6); rw_wrn = 1'b1; wait_n(6);
      en_rdn = 1'b0; wait_n(6);
      chk(db_oe == 1'b0, "R1 no parallel read in serial", db_oe, 0);
      en_rdn = 1'b1;
      expect_none("R1 no parallel write in serial");

      // random mix, R11 one pulse each
      for (int k = 0; k < 30; k++) begin
         int style;
         style = $urandom % 3;
         rs = $urandom % 2;
         d = $urandom % 256;
         if (!rs && d[7:5] == 3'b001) d[7:5] = 3'b000;
         select(style);
         if (style == 0) ser_xfer({1'b0, rs, 6'b0, d}, 16, got);
         else par_pulse(rs, d);
         expect_wr(rs, d, "R11 random write");
      end
      chk(wide_m == 1'b1, "R6 model width", wide_m, 1);
      finish_run();
   end
endmodule